// File: doc/BRIEF.md
# Two-Bank Interleaved Dual-Request Memory

This block is a word-addressed memory built from two single-ported storage banks. The least significant bit of the word address picks the bank, and the remaining bits pick the row inside it. Two request ports each present one read or one write per cycle under a valid/ready handshake. When the two requests fall in different banks, both are served in the same cycle. This gives twice the throughput of one single-ported array, without dual-ported cells.

When both requests target the same bank, the block serializes them. Port 0 goes to the bank first. The port 1 request is still accepted, but it is parked in a one-entry hold register and sent to the bank on the next cycle. While that parked request is pending, port 1 sees ready low. A new port 0 request that collides with the parked request is also refused for that cycle. Read data comes back one cycle after the bank access and is marked by a per-port response valid flag. Each port receives its read results in the order it issued them.

Top module: `ilv_mem`

## Requirements
- R1: Word address bit 0 selects the bank (0 or 1) and the upper address bits select the row; a write followed later by a read of the same address on either port returns the written data.
- R2: When both ports present requests to different banks and no parked request exists, both ready outputs are high and both requests are served in that cycle.
- R3: When both ports present requests to the same bank and no parked request exists, both are accepted; port 0 is served in that cycle and the port 1 request is served in the next cycle.
- R4: In the cycle after a port 1 request was parked, port 1 ready is low, so no new port 1 request can overtake the parked one.
- R5: While a parked port 1 request is pending, port 0 ready is low if the port 0 address (whether or not valid) selects the same bank as the parked request, and high otherwise.
- R6: A served read raises that port's response valid for exactly one cycle, in the cycle right after the bank access, together with the read data; a write produces no response.
- R7: Read responses on each port appear in the order that port's requests were accepted, including across a parked request.
- R8: Same-bank conflicts are resolved port 0 first: a port 1 read of an address that port 0 writes in the same cycle returns the new data, and a port 0 read of an address that port 1 writes in the same cycle returns the old data.
- R9: Synchronous reset drops any parked request and pending responses: afterwards both ready outputs are high and both response valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_req_valid | input | 1 | Port 0 request present |
| p0_req_ready | output | 1 | Port 0 request accepted this cycle when valid |
| p0_req_we | input | 1 | Port 0 write (1) or read (0) |
| p0_req_addr | input | 6 | Port 0 word address |
| p0_req_wdata | input | 16 | Port 0 write data |
| p0_rsp_valid | output | 1 | Port 0 read data valid |
| p0_rsp_rdata | output | 16 | Port 0 read data |
| p1_req_valid | input | 1 | Port 1 request present |
| p1_req_ready | output | 1 | Port 1 request accepted this cycle when valid |
| p1_req_we | input | 1 | Port 1 write (1) or read (0) |
| p1_req_addr | input | 6 | Port 1 word address |
| p1_req_wdata | input | 16 | Port 1 write data |
| p1_rsp_valid | output | 1 | Port 1 read data valid |
| p1_rsp_rdata | output | 16 | Port 1 read data |

## Verification
Two of the block's functions can fall in the same cycle. One is the issue of a parked port 1 request. The other is a fresh port 0 request, which may or may not hit the same bank. The bench provokes this by first creating a same-bank collision and then, on the next cycle, presenting a port 0 address in either the parked request's bank or the other bank. It then judges port 0 ready in that cycle and checks the response data and its ordering on both ports one cycle later. Write/read pairs to one address in a single cycle, in both port orders, show which access the bank saw first.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int unsigned AW     = 6;
    localparam int unsigned DW     = 16;
    localparam int unsigned NBANK  = 2;
    localparam int unsigned BANK_W = $clog2(NBANK);
    localparam int unsigned ROW_W  = AW - BANK_W;
    localparam int unsigned DEPTH  = 1 << ROW_W;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } mreq_t;

    typedef struct packed {
        logic             en;
        logic             we;
        logic [ROW_W-1:0] row;
        logic [DW-1:0]    wdata;
    } bcmd_t;

    function automatic logic [BANK_W-1:0] bank_of(input logic [AW-1:0] a);
        return a[BANK_W-1:0];
    endfunction

    function automatic logic [ROW_W-1:0] row_of(input logic [AW-1:0] a);
        return a[AW-1:BANK_W];
    endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank
    import ilv_pkg::*;
(
    input  logic          clk,
    input  bcmd_t         cmd,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (cmd.en) begin
            if (cmd.we) mem[cmd.row] <= cmd.wdata;
            else        rdata        <= mem[cmd.row];
        end
    end
endmodule

// File: rtl/ilv_arb.sv
module ilv_arb
    import ilv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  p0_valid,
    input  mreq_t p0_req,
    output logic  p0_ready,
    input  logic  p1_valid,
    input  mreq_t p1_req,
    output logic  p1_ready,
    output logic  iss0_v,
    output mreq_t iss0,
    output logic  iss1_v,
    output mreq_t iss1
);
    logic  hold_v;
    mreq_t hold_q;
    logic  p1_acc;
    logic  clash;

    always_comb begin
        p1_ready = !hold_v;
        p0_ready = !(hold_v && (bank_of(p0_req.addr) == bank_of(hold_q.addr)));
        iss0_v   = p0_valid && p0_ready;
        iss0     = p0_req;
        p1_acc   = p1_valid && p1_ready;
        clash    = p1_acc && iss0_v && (bank_of(p0_req.addr) == bank_of(p1_req.addr));
        iss1_v   = hold_v || (p1_acc && !clash);
        iss1     = hold_v ? hold_q : p1_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v <= 1'b0;
            hold_q <= '0;
        end else begin
            hold_v <= clash;
            if (clash) hold_q <= p1_req;
        end
    end

    // R3
    park_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (p0_valid && p0_ready && p1_valid && p1_ready &&
         bank_of(p0_req.addr) == bank_of(p1_req.addr))
        |=> (iss1_v && iss1 == $past(p1_req)));

    // R4
    park_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (p0_valid && p0_ready && p1_valid && p1_ready &&
         bank_of(p0_req.addr) == bank_of(p1_req.addr))
        |=> !p1_ready);

    // R2
    split_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (p0_valid && p1_valid && p1_ready &&
         bank_of(p0_req.addr) != bank_of(p1_req.addr))
        |-> (iss0_v && iss1_v));
endmodule

// File: rtl/ilv_rsp.sv
module ilv_rsp
    import ilv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_v,
    input  logic              iss_we,
    input  logic [BANK_W-1:0] iss_bank,
    input  logic [DW-1:0]     bank_rdata [NBANK],
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_rdata
);
    logic [BANK_W-1:0] bank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            bank_q    <= '0;
        end else begin
            rsp_valid <= iss_v && !iss_we;
            if (iss_v) bank_q <= iss_bank;
        end
    end

    assign rsp_rdata = bank_rdata[bank_q];
endmodule

// File: rtl/ilv_mem.sv
module ilv_mem
    import ilv_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          p0_req_valid,
    output logic          p0_req_ready,
    input  logic          p0_req_we,
    input  logic [AW-1:0] p0_req_addr,
    input  logic [DW-1:0] p0_req_wdata,
    output logic          p0_rsp_valid,
    output logic [DW-1:0] p0_rsp_rdata,
    input  logic          p1_req_valid,
    output logic          p1_req_ready,
    input  logic          p1_req_we,
    input  logic [AW-1:0] p1_req_addr,
    input  logic [DW-1:0] p1_req_wdata,
    output logic          p1_rsp_valid,
    output logic [DW-1:0] p1_rsp_rdata
);
    mreq_t r0, r1, i0, i1;
    logic  i0v, i1v;
    bcmd_t cmd [NBANK];
    logic [DW-1:0] brd [NBANK];
    logic [NBANK-1:0] sel0, sel1, rd0, rd1;

    assign r0 = '{we: p0_req_we, addr: p0_req_addr, wdata: p0_req_wdata};
    assign r1 = '{we: p1_req_we, addr: p1_req_addr, wdata: p1_req_wdata};

    ilv_arb u_arb (
        .clk(clk), .rst(rst),
        .p0_valid(p0_req_valid), .p0_req(r0), .p0_ready(p0_req_ready),
        .p1_valid(p1_req_valid), .p1_req(r1), .p1_ready(p1_req_ready),
        .iss0_v(i0v), .iss0(i0), .iss1_v(i1v), .iss1(i1)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign sel0[b] = i0v && (bank_of(i0.addr) == BANK_W'(b));
        assign sel1[b] = i1v && (bank_of(i1.addr) == BANK_W'(b));
        assign rd0[b]  = sel0[b] && !i0.we;
        assign rd1[b]  = sel1[b] && !i1.we;

        always_comb begin
            cmd[b].en    = sel0[b] || sel1[b];
            cmd[b].we    = sel0[b] ? i0.we : i1.we;
            cmd[b].row   = sel0[b] ? row_of(i0.addr) : row_of(i1.addr);
            cmd[b].wdata = sel0[b] ? i0.wdata : i1.wdata;
        end

        ilv_bank u_bank (.clk(clk), .cmd(cmd[b]), .rdata(brd[b]));

        // R3
        bank_single_chk: assert property (@(posedge clk) disable iff (rst)
            !(sel0[b] && sel1[b]));
    end

    ilv_rsp u_rsp0 (
        .clk(clk), .rst(rst), .iss_v(i0v), .iss_we(i0.we),
        .iss_bank(bank_of(i0.addr)), .bank_rdata(brd),
        .rsp_valid(p0_rsp_valid), .rsp_rdata(p0_rsp_rdata)
    );

    ilv_rsp u_rsp1 (
        .clk(clk), .rst(rst), .iss_v(i1v), .iss_we(i1.we),
        .iss_bank(bank_of(i1.addr)), .bank_rdata(brd),
        .rsp_valid(p1_rsp_valid), .rsp_rdata(p1_rsp_rdata)
    );

    // R6
    rsp0_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        p0_rsp_valid |-> $past(|rd0));

    // R6
    rsp1_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        p1_rsp_valid |-> $past(|rd1));
endmodule

// File: tb/tb_ilv_mem.sv
module tb_ilv_mem;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        p0_req_valid = 0, p0_req_we = 0, p1_req_valid = 0, p1_req_we = 0;
    logic [5:0]  p0_req_addr = 0, p1_req_addr = 0;
    logic [15:0] p0_req_wdata = 0, p1_req_wdata = 0;
    logic        p0_req_ready, p1_req_ready, p0_rsp_valid, p1_rsp_valid;
    logic [15:0] p0_rsp_rdata, p1_rsp_rdata;

    ilv_mem dut (.*);

    typedef struct packed {
        logic       v0, w0; logic [5:0] a0; logic [15:0] d0;
        logic       v1, w1; logic [5:0] a1; logic [15:0] d1;
        logic       er0, er1;
        logic       ev0; logic [15:0] ed0;
        logic       ev1; logic [15:0] ed1;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        // c0  R2: different banks, both writes
        '{1,1,6'd2,16'h1111, 1,1,6'd3,16'h2222, 1,1, 0,16'h0, 0,16'h0},
        // c1  R3: same bank writes, port 1 parked
        '{1,1,6'd4,16'h3333, 1,1,6'd6,16'h4444, 1,1, 0,16'h0, 0,16'h0},
        // c2  R4/R5: parked issue, port 0 other bank
        '{1,1,6'd5,16'h5555, 0,0,6'd0,16'h0,    1,0, 0,16'h0, 0,16'h0},
        // c3  R1: reads of both banks
        '{1,0,6'd2,16'h0,    1,0,6'd3,16'h0,    1,1, 0,16'h0, 0,16'h0},
        // c4  R6: responses; same bank reads
        '{1,0,6'd4,16'h0,    1,0,6'd6,16'h0,    1,1, 1,16'h1111, 1,16'h2222},
        // c5  R5: port 0 same bank as parked -> refused
        '{1,0,6'd8,16'h0,    1,0,6'd5,16'h0,    0,0, 1,16'h3333, 0,16'h0},
        // c6  R7: parked read returns before later one
        '{1,0,6'd2,16'h0,    1,0,6'd5,16'h0,    1,1, 0,16'h0, 1,16'h4444},
        // c7  R8: p0 write, p1 read same address
        '{1,1,6'd10,16'h6666,1,0,6'd10,16'h0,   1,1, 1,16'h1111, 1,16'h5555},
        // c8  R5: port 0 other bank during park
        '{1,0,6'd3,16'h0,    0,0,6'd0,16'h0,    1,0, 0,16'h0, 0,16'h0},
        // c9  R8: p0 read, p1 write same address
        '{1,0,6'd10,16'h0,   1,1,6'd10,16'h7777,1,1, 1,16'h2222, 1,16'h6666},
        // c10 R4: port 1 refused while parked; idle p0 addr 0 same bank
        '{0,0,6'd0,16'h0,    1,0,6'd10,16'h0,   0,0, 1,16'h6666, 0,16'h0},
        // c11 R1: read back
        '{1,0,6'd10,16'h0,   1,0,6'd3,16'h0,    1,1, 0,16'h0, 0,16'h0},
        // c12 R6
        '{0,0,6'd1,16'h0,    0,0,6'd0,16'h0,    1,1, 1,16'h7777, 1,16'h2222},
        // c13 R6: writes give no response
        '{0,0,6'd1,16'h0,    0,0,6'd0,16'h0,    1,1, 0,16'h0, 0,16'h0}
    };

    function automatic string tag_of(input int i);
        case (i)
            0: return "R2";  1: return "R3";  2: return "R5";  3: return "R1";
            4: return "R6";  5: return "R5";  6: return "R7";  7: return "R8";
            8: return "R5";  9: return "R8";  10: return "R4"; 11: return "R1";
            default: return "R6";
        endcase
    endfunction

    int n_chk = 0, n_bad = 0;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive_idle();
        p0_req_valid = 0; p0_req_we = 0; p0_req_addr = 6'd1; p0_req_wdata = 0;
        p1_req_valid = 0; p1_req_we = 0; p1_req_addr = 6'd0; p1_req_wdata = 0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        drive_idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R9: reset state
        check("R9", "p0_ready", p0_req_ready, 1);
        check("R9", "p1_ready", p1_req_ready, 1);
        check("R9", "p0_rsp_valid", p0_rsp_valid, 0);
        check("R9", "p1_rsp_valid", p1_rsp_valid, 0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            check(tag_of(i), "p0_rsp_valid", p0_rsp_valid, TBL[i].ev0);
            check(tag_of(i), "p1_rsp_valid", p1_rsp_valid, TBL[i].ev1);
            if (TBL[i].ev0) check(tag_of(i), "p0_rsp_rdata", p0_rsp_rdata, TBL[i].ed0);
            if (TBL[i].ev1) check(tag_of(i), "p1_rsp_rdata", p1_rsp_rdata, TBL[i].ed1);
            p0_req_valid = TBL[i].v0; p0_req_we = TBL[i].w0;
            p0_req_addr  = TBL[i].a0; p0_req_wdata = TBL[i].d0;
            p1_req_valid = TBL[i].v1; p1_req_we = TBL[i].w1;
            p1_req_addr  = TBL[i].a1; p1_req_wdata = TBL[i].d1;
            #1;
            check(tag_of(i), "p0_ready", p0_req_ready, TBL[i].er0);
            check(tag_of(i), "p1_ready", p1_req_ready, TBL[i].er1);
        end

        // R9: reset drops a parked request and a pending read response
        @(negedge clk);
        p0_req_valid = 1; p0_req_we = 0; p0_req_addr = 6'd2;
        p1_req_valid = 1; p1_req_we = 0; p1_req_addr = 6'd4;
        @(negedge clk);
        drive_idle();
        p0_req_addr = 6'd0;
        #1;
        check("R5", "p0_ready idle addr same bank as parked", p0_req_ready, 0);
        rst = 1;
        @(negedge clk);
        rst = 0;
        #1;
        check("R9", "p1_ready after reset", p1_req_ready, 1);
        check("R9", "p0_ready after reset", p0_req_ready, 1);
        check("R9", "p0_rsp_valid after reset", p0_rsp_valid, 0);
        check("R9", "p1_rsp_valid after reset", p1_rsp_valid, 0);
        @(negedge clk);
        check("R9", "no late parked response", p1_rsp_valid, 0);

        // R1: highest address in each bank
        p0_req_valid = 1; p0_req_we = 1; p0_req_addr = 6'd62; p0_req_wdata = 16'hA5A5;
        p1_req_valid = 1; p1_req_we = 1; p1_req_addr = 6'd63; p1_req_wdata = 16'h5A5A;
        @(negedge clk);
        p0_req_we = 0; p0_req_addr = 6'd63;
        p1_req_we = 0; p1_req_addr = 6'd62;
        @(negedge clk);
        drive_idle();
        check("R1", "p0 cross read valid", p0_rsp_valid, 1);
        check("R1", "p0 cross read data", p0_rsp_rdata, 16'h5A5A);
        check("R1", "p1 cross read valid", p1_rsp_valid, 1);
        check("R1", "p1 cross read data", p1_rsp_rdata, 16'hA5A5);
        @(negedge clk);
        check("R6", "p0 single-cycle response", p0_rsp_valid, 0);

        finish_run();
    end
endmodule